// File: doc/BRIEF.md
# Indexed Configuration RAM with Lazy Checksum

This block holds a 64-byte configuration store that a host reaches through two byte-wide ports selected by one signal: an index port that holds the address, and a data port that reads or writes the byte that address selects. The whole store is loaded from an image parameter at reset, so one netlist can start from any configuration.

Two bytes of the store hold a 16-bit checksum over a fixed window of configuration bytes. The checksum is not computed at reset. It is computed the first time the data port is used after reset. That first data access is held off with `ready` low while a sequencer adds one byte per cycle. The sum is then written into its two slots, and only after that is the stalled access serviced. Later writes never trigger a recomputation, so software that edits the window must also write the checksum bytes itself.

A request is presented with `req`, `sel_data`, `we` and `wdata`, and must be held until `ready` is high. The access completes on the rising clock edge where `req` and `ready` are both high. During that cycle, `rdata` carries the read result.

Top module: `cmos_idx_ram`

## Requirements
- R1: A write to the index port (`sel_data`=0) stores bits 6:0 of `wdata`. A read of the index port returns the stored index, with bit 7 equal to 0. Index port accesses are never stalled.
- R2: A data port access (`sel_data`=1) uses only bits 5:0 of the stored index, so index values 64 to 127 reach the same bytes as 0 to 63.
- R3: The checksum is the 16-bit sum, wrapping modulo 65536, of the bytes at addresses 0x10 through 0x2C inclusive. Its high byte is stored at 0x2E and its low byte at 0x2F.
- R4: On the first data port access after reset, `ready` stays low for exactly 30 cycles of the held request. The checksum is stored before the access completes, so a first read of 0x2E or 0x2F returns the new checksum.
- R5: After the checksum has been stored once, further data writes (including writes inside the summed window) leave 0x2E and 0x2F unchanged. Later data accesses are never stalled.
- R6: A data write to 0x2E or 0x2F overwrites that byte directly. This holds even when the write is the first data access, in which case the written value replaces the freshly stored checksum byte.
- R7: Reset loads byte i of the store from bits [8i+7:8i] of the image parameter and clears the index to 0. The default image holds 0x0280 at 0x15 (low) and 0x16 (high), and 0x3B00 at 0x17 (low) and 0x18 (high).
- R8: A completed data write stores `wdata` at the selected byte. `rdata` is 0 in any cycle in which no read completes, which includes write cycles and stalled cycles.
- R9: When the first data access is a write into the summed window, the checksum uses the byte's contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until `ready` is high |
| sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| we | input | 1 | 1 for a write, 0 for a read |
| wdata | input | 8 | Write value |
| ready | output | 1 | The access completes on this cycle's rising edge |
| rdata | output | 8 | Read result, valid while `req` and `ready` are high on a read |

## Verification
The checksum store and the stalled first access land in the same cycle. The sequencer's final add writes 0x2E and 0x2F on the same edge at which it raises the completion flag. The pending access is then serviced on the very next edge, so it must see the new bytes.

The bench provokes this case from three fresh resets:
- a first access that reads 0x2E through an aliased index;
- a first access that writes 0x2F;
- a first access that writes a byte inside the summed window.

A behavioural model predicts `ready` and `rdata` on every cycle of each access. In the write-to-0x2F case, the written byte must win over the checksum byte while 0x2E keeps the sum. In the in-window write case, the sum must reflect the byte's old value.

// File: rtl/cmos_pkg.sv
package cmos_pkg;

  localparam int unsigned IMG_BYTES = 64;
  localparam int unsigned IMG_BITS  = IMG_BYTES * 8;

  typedef logic [15:0] csum_t;

  // Running checksum step: wrap-around 16-bit addition of one byte.
  function automatic csum_t csum_add(input csum_t acc, input logic [7:0] b);
    return acc + {8'h00, b};
  endfunction

  // Default reset image: a filler pattern plus the memory-size words.
  function automatic logic [IMG_BITS-1:0] default_image();
    logic [IMG_BITS-1:0] img;
    img = '0;
    for (int i = 0; i < IMG_BYTES; i++) begin
      img[i*8 +: 8] = 8'((i * 13 + 33) % 256);
    end
    img[8'h15*8 +: 8] = 8'h80;
    img[8'h16*8 +: 8] = 8'h02;
    img[8'h17*8 +: 8] = 8'h00;
    img[8'h18*8 +: 8] = 8'h3B;
    return img;
  endfunction

endpackage

// File: rtl/cmos_index_reg.sv
module cmos_index_reg #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [IW-1:0] idx_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (wr_en) begin
      idx_q <= wdata[IW-1:0];
    end
  end

  AST_IDX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (idx_q == $past(wdata[IW-1:0]))); // R1

endmodule

// File: rtl/cmos_byte_store.sv
module cmos_byte_store #(
  parameter int unsigned        DEPTH   = 64,
  parameter int unsigned        DW      = 8,
  parameter int unsigned        AW      = 6,
  parameter int unsigned        CK_HI   = 46,
  parameter int unsigned        CK_LO   = 47,
  parameter logic [DEPTH*DW-1:0] IMAGE  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic [AW-1:0]   scan_addr,
  output logic [DW-1:0]   scan_rdata,
  input  logic            ck_we,
  input  logic [2*DW-1:0] ck_sum
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        mem[i] <= IMAGE[i*DW +: DW];
      end
    end else if (ck_we) begin
      mem[CK_HI] <= ck_sum[2*DW-1:DW];
      mem[CK_LO] <= ck_sum[DW-1:0];
    end else if (host_we) begin
      mem[host_addr] <= host_wdata;
    end
  end

  assign host_rdata = mem[host_addr];
  assign scan_rdata = mem[scan_addr];

  // The checksum store and a host write never meet: the host is stalled.
  AST_STORE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ck_we && host_we)); // R4

  AST_CK_HI_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ck_we |=> (mem[CK_HI] == $past(ck_sum[2*DW-1:DW]))); // R3

endmodule

// File: rtl/cmos_csum_engine.sv
module cmos_csum_engine #(
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 6,
  parameter int unsigned SUM_LO = 16,
  parameter int unsigned SUM_HI = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [AW-1:0]   scan_addr,
  input  logic [DW-1:0]   scan_rdata,
  output logic            busy,
  output logic            done,
  output logic            ck_we,
  output logic [2*DW-1:0] ck_sum
);
  import cmos_pkg::*;

  localparam logic [AW-1:0] FIRST = AW'(SUM_LO);
  localparam logic [AW-1:0] LAST  = AW'(SUM_HI);

  logic [AW-1:0]   ptr_q;
  logic [2*DW-1:0] acc_q;
  logic            last_step;

  assign scan_addr = ptr_q;
  assign last_step = busy && (ptr_q == LAST);
  assign ck_sum    = csum_add(acc_q, scan_rdata);
  assign ck_we     = last_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      ptr_q <= FIRST;
      acc_q <= '0;
    end else if (start && !busy && !done) begin
      busy  <= 1'b1;
      ptr_q <= FIRST;
      acc_q <= '0;
    end else if (busy) begin
      acc_q <= ck_sum;
      ptr_q <= ptr_q + 1'b1;
      if (last_step) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  AST_SCAN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ptr_q >= FIRST && ptr_q <= LAST)); // R3

  AST_RUN_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R5

  AST_NO_RESUM: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5

endmodule

// File: rtl/cmos_idx_ram.sv
module cmos_idx_ram #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DW     = 8,
  parameter int unsigned IW     = 7,
  parameter int unsigned SUM_LO = 16,
  parameter int unsigned SUM_HI = 44,
  parameter int unsigned CK_HI  = 46,
  parameter int unsigned CK_LO  = 47,
  parameter logic [DEPTH*DW-1:0] IMAGE = cmos_pkg::default_image()
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          sel_data,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic [IW-1:0]   idx_q;
  logic [DW-1:0]   host_rdata;
  logic [AW-1:0]   scan_addr;
  logic [DW-1:0]   scan_rdata;
  logic            ck_busy;
  logic            ck_done;
  logic            ck_we;
  logic [2*DW-1:0] ck_sum;

  // Named internal events.
  logic data_req;
  logic idx_wr;
  logic data_wr;
  logic read_fire;
  logic ck_start;

  assign data_req  = req && sel_data;
  assign ready     = !(data_req && !ck_done);
  assign ck_start  = data_req && !ck_done && !ck_busy;
  assign idx_wr    = req && !sel_data && we;
  assign data_wr   = data_req && we && ck_done;
  assign read_fire = req && ready && !we;

  cmos_index_reg #(.DW(DW), .IW(IW)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (idx_wr),
    .wdata (wdata),
    .idx_q (idx_q)
  );

  cmos_byte_store #(
    .DEPTH(DEPTH), .DW(DW), .AW(AW), .CK_HI(CK_HI), .CK_LO(CK_LO), .IMAGE(IMAGE)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (data_wr),
    .host_addr  (idx_q[AW-1:0]),
    .host_wdata (wdata),
    .host_rdata (host_rdata),
    .scan_addr  (scan_addr),
    .scan_rdata (scan_rdata),
    .ck_we      (ck_we),
    .ck_sum     (ck_sum)
  );

  cmos_csum_engine #(
    .DW(DW), .AW(AW), .SUM_LO(SUM_LO), .SUM_HI(SUM_HI)
  ) u_ck (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ck_start),
    .scan_addr  (scan_addr),
    .scan_rdata (scan_rdata),
    .busy       (ck_busy),
    .done       (ck_done),
    .ck_we      (ck_we),
    .ck_sum     (ck_sum)
  );

  always_comb begin
    rdata = '0;
    if (read_fire) begin
      if (sel_data) rdata = host_rdata;
      else          rdata = {{(DW-IW){1'b0}}, idx_q};
    end
  end

  AST_STALL_UNTIL_SUMMED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && !ck_done) |-> !ready); // R4

  AST_INDEX_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !sel_data) |-> ready); // R1

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !read_fire |-> (rdata == '0)); // R8

  AST_CK_ONLY_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ck_we |-> !ck_done); // R5

endmodule

// File: tb/cmos_idx_ram_tb.sv
module cmos_idx_ram_tb;

  function automatic logic [511:0] tb_image();
    logic [511:0] img;
    for (int i = 0; i < 64; i++) img[i*8 +: 8] = 8'((i * 29 + 7) % 256);
    img[8'h15*8 +: 8] = 8'h80;
    img[8'h16*8 +: 8] = 8'h02;
    img[8'h17*8 +: 8] = 8'h00;
    img[8'h18*8 +: 8] = 8'h3B;
    return img;
  endfunction

  localparam logic [511:0] IMG = tb_image();

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       sel_data = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       ready;
  logic [7:0] rdata;

  always #5 clk = ~clk;

  cmos_idx_ram #(.IMAGE(IMG)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .sel_data(sel_data),
    .we(we), .wdata(wdata), .ready(ready), .rdata(rdata)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Behavioural reference model
  int m_mem [64];
  int m_idx;
  bit m_done;

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_mem[i] = int'(IMG[i*8 +: 8]);
    m_idx = 0;
    m_done = 0;
  endtask

  task automatic model_sum();
    int s = 0;
    for (int a = 16; a <= 44; a++) s = s + m_mem[a];
    s = s % 65536;
    m_mem[46] = s / 256;
    m_mem[47] = s % 256;
    m_done = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // One access, compared against the model on every clock until it completes.
  task automatic access(input bit s, input bit w, input logic [7:0] d, input string tag);
    int stall = 0;
    int exp_stall;
    int exp_rd;
    exp_stall = (s && !m_done) ? 30 : 0;
    if (s && !m_done) model_sum();
    @(negedge clk);
    req = 1'b1; sel_data = s; we = w; wdata = d;
    forever begin
      #2;
      chk(ready == (stall >= exp_stall), {tag, " ready"}, int'(ready), int'(stall >= exp_stall));
      if (ready) begin
        if (w) exp_rd = 0;
        else if (!s) exp_rd = m_idx;
        else exp_rd = m_mem[m_idx % 64];
        chk(rdata == 8'(exp_rd), {tag, " rdata"}, int'(rdata), exp_rd);
        break;
      end
      chk(rdata == 8'h00, "R8 stalled rdata", int'(rdata), 0);
      stall++;
      if (stall > 60) begin
        chk(1'b0, {tag, " stall limit"}, stall, exp_stall);
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    if (!s && w) m_idx = int'(d) % 128;
    if (s && w) m_mem[m_idx % 64] = int'(d);
    @(negedge clk);
    req = 1'b0; we = 1'b0; sel_data = 1'b0;
  endtask

  task automatic set_idx(input logic [7:0] v);
    access(1'b0, 1'b1, v, "R1 index write");
  endtask

  task automatic read_at(input logic [7:0] a, input string tag);
    set_idx(a);
    access(1'b1, 1'b0, 8'h00, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R7 / R8 reset state
    #2;
    chk(ready == 1'b1, "R8 idle ready", int'(ready), 1);
    chk(rdata == 8'h00, "R8 idle rdata", int'(rdata), 0);
    access(1'b0, 1'b0, 8'h00, "R7 index after reset");

    // R1: bit 7 dropped; R2: alias; R4/R3: first read of 0x2E via alias 0x6E
    set_idx(8'hEE);
    access(1'b0, 1'b0, 8'h00, "R1 index readback");
    access(1'b1, 1'b0, 8'h00, "R4 R2 first read of checksum hi");
    read_at(8'h2F, "R3 checksum lo");
    read_at(8'h15, "R7 base mem lo");
    read_at(8'h16, "R7 base mem hi");
    read_at(8'h17, "R7 ext mem lo");
    read_at(8'h18, "R7 ext mem hi");
    read_at(8'h55, "R2 alias of 0x15");

    // R5/R8: write into window, no recompute, no stall
    set_idx(8'h10);
    access(1'b1, 1'b1, 8'hA5, "R8 data write");
    access(1'b1, 1'b0, 8'h00, "R8 data readback");
    read_at(8'h2E, "R5 checksum hi unchanged");
    read_at(8'h2F, "R5 checksum lo unchanged");

    // R6: direct overwrite after init
    set_idx(8'h2F);
    access(1'b1, 1'b1, 8'h3C, "R6 overwrite lo");
    access(1'b1, 1'b0, 8'h00, "R6 overwrite lo readback");

    // R6: first access is a write to 0x2F
    do_reset();
    set_idx(8'h2F);
    access(1'b1, 1'b1, 8'h77, "R6 R4 first write to 0x2F");
    access(1'b1, 1'b0, 8'h00, "R6 written byte wins");
    read_at(8'h2E, "R3 checksum hi kept");

    // R9: first access writes inside the window
    do_reset();
    set_idx(8'h12);
    access(1'b1, 1'b1, 8'hFF, "R9 R4 first write in window");
    access(1'b1, 1'b0, 8'h00, "R9 window byte written");
    read_at(8'h2E, "R9 sum hi uses old byte");
    read_at(8'h2F, "R9 sum lo uses old byte");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule